// File: doc/BRIEF.md
# Three-Phase to Rotating-Frame (d/q) Transform

This block takes three signed phase samples and an electrical angle and produces the direct (d) and quadrature (q) components in the frame that rotates with that angle. A sample set enters with a single-cycle valid strobe while the block reports itself ready. The block then runs a fixed schedule of nine steps on one shared signed multiplier. The first three steps turn each of the three phase angles into a table index and fetch that phase's sine and cosine from a small internal table. The next three steps accumulate the d sum. The last three accumulate the q sum.

Each phase has its own angle. Phase a uses the input angle. Phase b uses the angle less 2pi/3, and phase c uses the angle plus 2pi/3, with pi taken as 3.1416 in the angle's fixed-point scale. Every phase angle is folded into [0, 2pi) before its lookup. The 2/3 scale factor is built into the table entries, so no extra multiply is spent on it. Both results appear together, marked by a one-cycle valid pulse, and they stay on the outputs until the next result replaces them.

Top module: `park_dq_xform`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, and `out_d` and `out_q` are 0.
- R2: `in_ready` is 1 only while the block is idle, and it falls in the cycle after an input is taken. A strobe on `in_valid` while `in_ready` is 0 is ignored: it yields no result and does not change the result that is in progress.
- R3: `out_valid` rises on the ninth rising clock edge after the edge that took the input.
- R4: `out_d` equals (2/3)·(a·cos θa + b·cos θb + c·cos θc), rounded to an integer. The table has 2^NL entries per turn, so the error is within 1% of |a|+|b|+|c| plus a few LSB.
- R5: `out_q` equals −(2/3)·(a·sin θa + b·sin θb + c·sin θc), within the same bound as R4.
- R6: θa is the input angle, θb is the angle − 2·3.1416/3 and θc is the angle + 2·3.1416/3. A balanced set a = A·cos θ, b = A·cos(θ−2pi/3), c = A·cos(θ+2pi/3) therefore gives d ≈ A and q ≈ 0.
- R7: `in_angle` is unsigned radians with AF fractional bits and AW−AF = 3 integer bits. Every phase angle is folded into [0, 2·3.1416) before the lookup, so an input angle of θ + 2·3.1416 (in LSB) gives results bit-identical to θ.
- R8: `out_valid` is a one-cycle pulse. `out_d` and `out_q` change only in a cycle where `out_valid` is 1, and they hold their values otherwise.
- R9: When inputs are offered back to back, results come out every 10 cycles, because the block takes a new input on the edge that ends the `out_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample set is present |
| in_ready | output | 1 | Block is idle and takes input this cycle |
| in_ph_a | input | DW | Phase a sample, signed |
| in_ph_b | input | DW | Phase b sample, signed |
| in_ph_c | input | DW | Phase c sample, signed |
| in_angle | input | AW | Electrical angle, unsigned, AF fractional bits |
| out_valid | output | 1 | One-cycle result strobe |
| out_d | output | OW | Direct component, signed |
| out_q | output | OW | Quadrature component, signed |

## Verification
The bench builds the block with its defaults: 16-bit samples, a 16-bit angle with 13 fractional bits, 16-bit table words, a 256-entry table and rounded output. The 16-bit samples let the bench drive full-scale ±32768 sets, which exercise the widest accumulator sums. The three integer bits of the angle allow inputs up to 8 rad, so the bench can compare an angle above 2pi bit-for-bit against the same angle less one turn. The 256-entry table keeps the lookup error well inside the 1% bound used by the real-valued reference, and that same bound still exposes any swapped phase, sign or offset.

// File: rtl/park_pkg.sv
package park_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } park_st_e;

   // Order of the three MAC groups; d always completes before q.
   typedef enum logic [1:0] {
      GRP_TRIG = 2'd0,
      GRP_DSUM = 2'd1,
      GRP_QSUM = 2'd2
   } park_grp_e;

   localparam real PI_SPEC = 3.1416;          // pi as used for angle arithmetic
   localparam real PI_TRUE = 3.14159265358979; // pi for table synthesis
   localparam int  N_PHASE = 3;

   function automatic int rnd_real(input real x);
      if (x >= 0.0) return $rtoi(x + 0.5);
      else          return -$rtoi(0.5 - x);
   endfunction

endpackage

// File: rtl/park_angle_wrap.sv
module park_angle_wrap #(
   parameter int AW = 16,
   parameter int AF = 13
) (
   input  logic [AW-1:0]        ang_i,
   output logic [2:0][AW-1:0]   wrap_o
);
   import park_pkg::*;

   localparam int EW       = AW + 2;
   localparam int TWO_PI_Q = rnd_real(2.0 * PI_SPEC * (2.0 ** AF));
   localparam int THIRD_Q  = rnd_real(2.0 * PI_SPEC / 3.0 * (2.0 ** AF));
   localparam logic signed [EW-1:0] TWO_PI_E = EW'(TWO_PI_Q);

   for (genvar p = 0; p < N_PHASE; p++) begin : g_ph
      localparam int OFS = (p == 0) ? 0 : ((p == 1) ? -THIRD_Q : THIRD_Q);
      localparam logic signed [EW-1:0] OFS_E = EW'(OFS);
      logic signed [EW-1:0] raw;
      logic signed [EW-1:0] fix;
      always_comb begin
         raw = $signed({2'b00, ang_i}) + OFS_E;
         if (raw < 0)              fix = raw + TWO_PI_E;
         else if (raw >= TWO_PI_E) fix = raw - TWO_PI_E;
         else                      fix = raw;
      end
      assign wrap_o[p] = AW'(fix);
   end

endmodule

// File: rtl/park_trig_rom.sv
module park_trig_rom #(
   parameter int NL = 8,
   parameter int TW = 16
) (
   input  logic [NL-1:0]        idx_i,
   output logic signed [TW-1:0] sin_o,
   output logic signed [TW-1:0] cos_o
);
   import park_pkg::*;

   localparam int N  = 1 << NL;
   localparam int TF = TW - 2;
   localparam logic [NL-1:0] QTR = NL'(N / 4);

   // Entries hold (2/3)*sin over one turn; cosine is the quarter-turn offset.
   logic signed [TW-1:0] tab [N];

   for (genvar i = 0; i < N; i++) begin : g_tab
      assign tab[i] = TW'(rnd_real(2.0 / 3.0 *
                      $sin(2.0 * PI_TRUE * real'(i) / real'(N)) * (2.0 ** TF)));
   end

   assign sin_o = tab[idx_i];
   assign cos_o = tab[idx_i + QTR];

endmodule

// File: rtl/park_mac.sv
module park_mac #(
   parameter int MA        = 17,
   parameter int MB        = 16,
   parameter int OW        = 18,
   parameter int TF        = 14,
   parameter bit ROUND_OUT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en_i,
   input  logic                    clr_i,
   input  logic                    sub_i,
   input  logic signed [MA-1:0]    a_i,
   input  logic signed [MB-1:0]    b_i,
   output logic signed [MA+MB-1:0] prod_o,
   output logic signed [OW-1:0]    res_o
);
   localparam int PW   = MA + MB;
   localparam int ACCW = PW + 2;
   localparam logic signed [ACCW-1:0] HALF = ACCW'(1) << (TF - 1);

   logic signed [ACCW-1:0] acc_q, base, nxt, rnd, shf;

   assign prod_o = a_i * b_i;

   always_comb begin
      base = clr_i ? '0 : acc_q;
      nxt  = sub_i ? (base - ACCW'(prod_o)) : (base + ACCW'(prod_o));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    acc_q <= '0;
      else if (en_i) acc_q <= nxt;
   end

   if (ROUND_OUT) begin : g_round
      assign rnd = nxt + HALF;
   end else begin : g_trunc
      assign rnd = nxt;
   end

   assign shf   = rnd >>> TF;
   assign res_o = OW'(shf);

endmodule

// File: rtl/park_dq_xform.sv
module park_dq_xform #(
   parameter int DW        = 16,
   parameter int AW        = 16,
   parameter int AF        = 13,
   parameter int TW        = 16,
   parameter int NL        = 8,
   parameter bit ROUND_OUT = 1'b1,
   parameter int OW        = DW + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic signed [DW-1:0] in_ph_a,
   input  logic signed [DW-1:0] in_ph_b,
   input  logic signed [DW-1:0] in_ph_c,
   input  logic [AW-1:0]        in_angle,
   output logic                 out_valid,
   output logic signed [OW-1:0] out_d,
   output logic signed [OW-1:0] out_q
);
   import park_pkg::*;

   localparam int TF       = TW - 2;
   localparam int N        = 1 << NL;
   localparam int TWO_PI_Q = rnd_real(2.0 * PI_SPEC * (2.0 ** AF));
   localparam int KS       = AW;
   localparam int K_Q      = rnd_real(real'(N) * (2.0 ** KS) / real'(TWO_PI_Q));
   localparam int KW       = $clog2(K_Q + 1);
   localparam int MA       = (DW > AW + 1) ? DW : AW + 1;
   localparam int MB       = (TW > KW + 1) ? TW : KW + 1;
   localparam int PW       = MA + MB;
   localparam logic [PW-1:0] HALF_IDX = PW'(1) << (KS - 1);

   if (AW - AF != 3) begin : g_chk_ang
      $error("angle must carry exactly three integer bits");
   end
   if (NL < 2 || NL > 12) begin : g_chk_nl
      $error("table size exponent out of range");
   end
   if (TW < 6) begin : g_chk_tw
      $error("table word too narrow");
   end
   if (KS + NL + 1 > PW) begin : g_chk_idx
      $error("product too narrow for index scaling");
   end
   if (OW < DW + 2) begin : g_chk_ow
      $error("output width must be at least DW+2");
   end

   park_st_e  st;
   park_grp_e grp;
   logic [1:0] ph;

   logic signed [DW-1:0] x_q   [N_PHASE];
   logic [AW-1:0]        th_q  [N_PHASE];
   logic signed [TW-1:0] sin_q [N_PHASE];
   logic signed [TW-1:0] cos_q [N_PHASE];
   logic signed [OW-1:0] d_pend, d_q, q_q;
   logic                 v_q;

   logic [2:0][AW-1:0]     wrap;
   logic signed [MA-1:0]   op_a;
   logic signed [MB-1:0]   op_b;
   logic signed [PW-1:0]   prod;
   logic signed [OW-1:0]   res;
   logic [PW-1:0]          isum;
   logic [NL-1:0]          idx;
   logic signed [TW-1:0]   rom_sin, rom_cos;
   logic                   mac_en, last_ph;

   park_angle_wrap #(.AW(AW), .AF(AF)) u_wrap (
      .ang_i (in_angle),
      .wrap_o(wrap)
   );

   // Operand selection for the single shared multiplier.
   always_comb begin
      unique case (grp)
         GRP_TRIG: begin
            op_a = MA'({1'b0, th_q[ph]});
            op_b = MB'(K_Q);
         end
         GRP_DSUM: begin
            op_a = MA'(x_q[ph]);
            op_b = MB'(cos_q[ph]);
         end
         default: begin
            op_a = MA'(x_q[ph]);
            op_b = MB'(sin_q[ph]);
         end
      endcase
   end

   assign mac_en  = (st == ST_BUSY) && (grp != GRP_TRIG);
   assign last_ph = (ph == 2'd2);

   park_mac #(.MA(MA), .MB(MB), .OW(OW), .TF(TF), .ROUND_OUT(ROUND_OUT)) u_mac (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (mac_en),
      .clr_i (ph == 2'd0),
      .sub_i (grp == GRP_QSUM),
      .a_i   (op_a),
      .b_i   (op_b),
      .prod_o(prod),
      .res_o (res)
   );

   assign isum = $unsigned(prod) + HALF_IDX;
   assign idx  = NL'(isum >> KS);

   park_trig_rom #(.NL(NL), .TW(TW)) u_rom (
      .idx_i(idx),
      .sin_o(rom_sin),
      .cos_o(rom_cos)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         grp    <= GRP_TRIG;
         ph     <= 2'd0;
         d_pend <= '0;
         d_q    <= '0;
         q_q    <= '0;
         v_q    <= 1'b0;
         for (int p = 0; p < N_PHASE; p++) begin
            x_q[p]   <= '0;
            th_q[p]  <= '0;
            sin_q[p] <= '0;
            cos_q[p] <= '0;
         end
      end else begin
         v_q <= 1'b0;
         if (st == ST_IDLE) begin
            if (in_valid) begin
               x_q[0] <= in_ph_a;
               x_q[1] <= in_ph_b;
               x_q[2] <= in_ph_c;
               for (int p = 0; p < N_PHASE; p++) th_q[p] <= wrap[p];
               st  <= ST_BUSY;
               grp <= GRP_TRIG;
               ph  <= 2'd0;
            end
         end else begin
            ph <= last_ph ? 2'd0 : ph + 2'd1;
            unique case (grp)
               GRP_TRIG: begin
                  sin_q[ph] <= rom_sin;
                  cos_q[ph] <= rom_cos;
                  if (last_ph) grp <= GRP_DSUM;
               end
               GRP_DSUM: begin
                  if (last_ph) begin
                     d_pend <= res;
                     grp    <= GRP_QSUM;
                  end
               end
               default: begin
                  if (last_ph) begin
                     d_q <= d_pend;
                     q_q <= res;
                     v_q <= 1'b1;
                     st  <= ST_IDLE;
                     grp <= GRP_TRIG;
                  end
               end
            endcase
         end
      end
   end

   assign in_ready  = (st == ST_IDLE);
   assign out_valid = v_q;
   assign out_d     = d_q;
   assign out_q     = q_q;

endmodule

// File: rtl/park_dq_chk.sv
module park_dq_chk #(
   parameter int OW = 18
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 in_ready,
   input logic                 out_valid,
   input logic signed [OW-1:0] out_d,
   input logic signed [OW-1:0] out_q
);
   // Counter reads 10 in the cycle that follows the ninth edge after acceptance.
   localparam logic [3:0] DUE = 4'd10;

   logic       armed;
   logic [3:0] lat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
         lat   <= '0;
      end else begin
         armed <= 1'b1;
         if (in_valid && in_ready) lat <= 4'd1;
         else if (out_valid)       lat <= '0;
         else if (lat != '0)       lat <= lat + 4'd1;
      end
   end

   a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (in_ready && !out_valid && out_d == '0 && out_q == '0));

   a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   a_r2_idle_at_result: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> in_ready);

   a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (lat == DUE));

   a_r3_result_due: assert property (@(posedge clk) disable iff (!rst_n)
      (lat == DUE) |-> out_valid);

   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !out_valid) |-> ($stable(out_d) && $stable(out_q)));

endmodule

bind park_dq_xform park_dq_chk #(.OW(OW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .out_d    (out_d),
   .out_q    (out_q)
);

// File: tb/sim_park_dq_xform.sv
module sim_park_dq_xform;
   localparam int DW = 16;
   localparam int AW = 16;
   localparam int AF = 13;
   localparam int TW = 16;
   localparam int NL = 8;
   localparam int OW = DW + 2;
   localparam real PI_S   = 3.1416;
   localparam real SCALE  = 8192.0;
   localparam int  TURN_Q = 51472;  // round(2*3.1416*2^13)

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [DW-1:0] pa = '0, pb = '0, pc = '0;
   logic [AW-1:0] ang = '0;
   logic in_ready, out_valid;
   logic signed [OW-1:0] out_d, out_q;

   always #2 clk = ~clk;

   park_dq_xform #(.DW(DW), .AW(AW), .AF(AF), .TW(TW), .NL(NL),
                   .ROUND_OUT(1'b1), .OW(OW)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_ph_a(pa), .in_ph_b(pb), .in_ph_c(pc), .in_angle(ang),
      .out_valid(out_valid), .out_d(out_d), .out_q(out_q));

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_bad = 0;
   int n_res = 0;
   int last_cyc = 0;
   int prev_cyc = 0;
   logic signed [OW-1:0] last_d = '0, last_q = '0;

   real   sb_d[$];
   real   sb_q[$];
   real   sb_tol[$];
   int    sb_cyc[$];
   string sb_tag[$];

   task automatic check(input bit ok, input string tag, input real act, input real exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0f expected %0f", tag, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard as results appear.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         real ed, eq, tl;
         int ec;
         string tg;
         n_res++;
         prev_cyc = last_cyc;
         last_cyc = cyc;
         last_d   = out_d;
         last_q   = out_q;
         if (sb_d.size() == 0) begin
            check(1'b0, "R2 unexpected result", real'(out_d), 0.0);
         end else begin
            ed = sb_d.pop_front();
            eq = sb_q.pop_front();
            tl = sb_tol.pop_front();
            ec = sb_cyc.pop_front();
            tg = sb_tag.pop_front();
            check(((real'(out_d) - ed) <= tl) && ((ed - real'(out_d)) <= tl),
                  {tg, " R4 d"}, real'(out_d), ed);
            check(((real'(out_q) - eq) <= tl) && ((eq - real'(out_q)) <= tl),
                  {tg, " R5 q"}, real'(out_q), eq);
            check(cyc == ec, {tg, " R3 latency"}, real'(cyc), real'(ec));
         end
      end
   end

   // Driver: offers one set and records what must come back.
   task automatic send(input int a, input int b, input int c, input int ang_i, input string tag);
      real th, tb2, tc2, d, q, tol;
      int  aa, ab, ac;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      th  = real'(ang_i) / SCALE;
      tb2 = th - 2.0 * PI_S / 3.0;
      tc2 = th + 2.0 * PI_S / 3.0;
      d   = 2.0 / 3.0 * (a * $cos(th) + b * $cos(tb2) + c * $cos(tc2));
      q   = -2.0 / 3.0 * (a * $sin(th) + b * $sin(tb2) + c * $sin(tc2));
      aa  = (a < 0) ? -a : a;
      ab  = (b < 0) ? -b : b;
      ac  = (c < 0) ? -c : c;
      tol = 0.01 * real'(aa + ab + ac) + 3.0;
      pa = DW'(a);  pb = DW'(b);  pc = DW'(c);  ang = AW'(ang_i);
      in_valid = 1'b1;
      sb_d.push_back(d);
      sb_q.push_back(q);
      sb_tol.push_back(tol);
      sb_cyc.push_back(cyc + 10);
      sb_tag.push_back(tag);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send_bal(input real amp, input real th, input string tag);
      send($rtoi(amp * $cos(th)), $rtoi(amp * $cos(th - 2.0 * PI_S / 3.0)),
           $rtoi(amp * $cos(th + 2.0 * PI_S / 3.0)), $rtoi(th * SCALE + 0.5), tag);
   endtask

   task automatic wait_done();
      while (sb_d.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "R3 watchdog", real'(cyc), 0.0);
      finish_run();
   end

   initial begin
      logic signed [OW-1:0] sd, sq;
      int hold_res;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle and cleared after reset
      check(in_ready == 1'b1, "R1 in_ready", real'(in_ready), 1.0);
      check(out_valid == 1'b0, "R1 out_valid", real'(out_valid), 0.0);
      check(out_d == '0 && out_q == '0, "R1 outputs", real'(out_d), 0.0);

      // R4/R5: single-phase and mixed sets
      send(0, 0, 0, 0, "R4 zero");
      send(10000, 0, 0, 0, "R4 phase a only");
      send(0, 10000, 0, 0, "R6 phase b offset");
      send(0, 0, -8000, 4096, "R6 phase c offset");
      send(12000, -7000, 3000, 20000, "R5 mixed");
      send(-32768, 32767, -32768, 51000, "R4 full scale");
      // R6: balanced sets land on d = A, q = 0
      send_bal(15000.0, 0.3, "R6 balanced 0.3");
      send_bal(15000.0, 1.7, "R6 balanced 1.7");
      send_bal(-9000.0, 3.0, "R6 balanced 3.0");
      send_bal(20000.0, 4.9, "R6 balanced 4.9");
      send_bal(15000.0, 6.0, "R6 balanced 6.0");
      wait_done();

      // R7: angle above one turn folds back exactly
      send(9000, -4000, 2500, 3000, "R7 base");
      wait_done();
      sd = last_d;
      sq = last_q;
      send(9000, -4000, 2500, 3000 + TURN_Q, "R7 plus one turn");
      wait_done();
      check(last_d == sd, "R7 d identical", real'(last_d), real'(sd));
      check(last_q == sq, "R7 q identical", real'(last_q), real'(sq));
      send(5000, 5000, -9000, 65535, "R7 top of range");
      wait_done();

      // R8: pulse and hold
      check(out_valid == 1'b0, "R8 pulse ended", real'(out_valid), 0.0);
      repeat (6) @(negedge clk);
      check(out_d == last_d && out_q == last_q, "R8 held", real'(out_d), real'(last_d));

      // R2: strobe while busy is ignored
      send(7000, 1000, -2000, 10000, "R2 kept result");
      @(negedge clk);
      check(in_ready == 1'b0, "R2 busy", real'(in_ready), 0.0);
      pa = 16'sd30000; pb = -16'sd30000; pc = 16'sd111; ang = 16'd40000;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      wait_done();
      hold_res = n_res;
      repeat (15) @(negedge clk);
      check(n_res == hold_res, "R2 no extra result", real'(n_res), real'(hold_res));

      // R9: back-to-back spacing
      send(4000, -4000, 0, 1234, "R9 first");
      send(-4000, 4000, 0, 5678, "R9 second");
      wait_done();
      check(last_cyc - prev_cyc == 10, "R9 spacing", real'(last_cyc - prev_cyc), 10.0);

      check(sb_d.size() == 0, "R2 all results seen", real'(sb_d.size()), 0.0);
      finish_run();
   end

endmodule